// File: doc/BRIEF.md
# Sparse Pixel Cluster Finder

This block takes the digitised rows of a column-parallel pixel sensor, one whole row of small ADC codes per row strobe, and reduces each frame to a sparse list of interesting pixels. Every 2×2 group of adjacent pixels, taken over the newest row and the row before it, is summed at all column positions at once. The sum is compared with one global threshold. A group whose sum is above the threshold marks a 7×7 patch of pixels around it for readout. Patches from nearby hits are merged, so no pixel is reported twice.

Marked pixels leave the block one per clock through an output FIFO. Each FIFO entry carries the row index, the column index and the original code. The block holds the last few rows in registers, so a row can be released only after every group that could still mark it has been evaluated. At the end of a frame the rows still held are drained. The consumer pops the FIFO at its own pace. The block never stalls the sensor. When the FIFO is full, entries are discarded and a sticky flag records the loss.

Top module: `pix_cluster_sparsifier`

## Requirements
- R1: The code of column c is `row_codes[5c+4:5c]`. The group anchored at row r and column c (pixels r and r+1 × c and c+1, for c from 0 to 123) is a hit only when the sum of its four codes is strictly greater than `thresh`. A sum equal to `thresh` is not a hit.
- R2: A hit anchored at (r, c) marks every pixel in rows r−3 to r+3 and columns c−3 to c+3, clipped to column 0..124 and to the rows of the current frame.
- R3: Marked regions that overlap are merged. Each marked pixel is reported exactly once per frame, and no unmarked pixel is reported.
- R4: Reports leave in ascending row order, and in ascending column order within a row. `out_row` is the row number within the frame, counting from 0. `out_col` is the column. `out_code` is the code received for that pixel.
- R5: Row p is released for readout when row p+4 arrives, or during the drain after the last row of the frame. Before that, none of its pixels reach the FIFO.
- R6: `out_valid` is high exactly while the FIFO holds an entry. A pop advances to the next entry. A pop while the FIFO is empty has no effect. Entries are held while no pop is given.
- R7: An entry produced while the FIFO is full is dropped and sets `overflow`. `overflow` stays set until reset. Entries already stored are unaffected. Filling the FIFO exactly to its depth does not set `overflow`.
- R8: After reset the FIFO is empty and `overflow` is low.
- R9: The row strobed with `row_last` ends the frame. The next row is row 0 of a new frame, and no mark from the previous frame reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | 7 | Global hit threshold on the 2×2 sum |
| row_valid | input | 1 | Strobe: `row_codes` holds a new row |
| row_last | input | 1 | With `row_valid`: this row ends the frame |
| row_codes | input | 625 | One 5-bit code per column, column c at bits 5c+4..5c |
| pop | input | 1 | Remove the entry shown at the output |
| out_valid | output | 1 | An entry is present |
| out_row | output | 8 | Row index of the entry |
| out_col | output | 7 | Column index of the entry |
| out_code | output | 5 | Pixel code of the entry |
| overflow | output | 1 | Sticky: an entry was lost to a full FIFO |

## Verification
The threshold is tried with a group summing exactly to it and then one count above it, which separates a strict comparison from an inclusive one. Hits placed in the four corners of a frame, and pairs of hits whose patches overlap, separate correct clipping and merging from wrap-around or duplicated reports. Random frames with a noisy background and injected groups, at random thresholds and frame heights, exercise the kernel across all columns. A row-by-row check shows exactly when a row is released. A frame that ends on a hit, followed by an empty frame, shows that marks do not leak between frames. A fill to exactly the FIFO depth and a fill beyond it separate the full condition from an off-by-one.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // clipping helpers for the readout window, evaluated at elaboration
  function automatic int win_lo(int c, int h);
    return (c - h < 0) ? 0 : c - h;
  endfunction

  function automatic int win_hi(int c, int h, int last);
    return (c + h > last) ? last : c + h;
  endfunction
endpackage

// File: rtl/pcs_hitmap.sv
module pcs_hitmap #(
  parameter int COLS   = 125,
  parameter int CODE_W = 5,
  parameter int HALF   = 3,
  localparam int SUM_W = CODE_W + 2,
  localparam int VW    = COLS * CODE_W
) (
  input  logic             en,
  input  logic [VW-1:0]    upper,
  input  logic [VW-1:0]    lower,
  input  logic [SUM_W-1:0] thresh,
  output logic [COLS-1:0]  colmask
);
  logic [COLS-2:0] hit;

  // one 2x2 adder and comparator per anchor column
  for (genvar c = 0; c < COLS - 1; c++) begin : g_kern
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(upper[c*CODE_W +: CODE_W]) + SUM_W'(upper[(c+1)*CODE_W +: CODE_W])
               + SUM_W'(lower[c*CODE_W +: CODE_W]) + SUM_W'(lower[(c+1)*CODE_W +: CODE_W]);
    assign hit[c] = en && (sum > thresh);
  end

  // a column is marked if any anchor within HALF of it fired
  for (genvar c = 0; c < COLS; c++) begin : g_spread
    localparam int LO = pcs_pkg::win_lo(c, HALF);
    localparam int HI = pcs_pkg::win_hi(c, HALF, COLS - 2);
    assign colmask[c] = |hit[HI:LO];
  end
endmodule

// File: rtl/pcs_rowscan.sv
module pcs_rowscan #(
  parameter int COLS   = 125,
  parameter int CODE_W = 5,
  parameter int ROW_W  = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int VW    = COLS * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [COLS-1:0]   load_mask,
  input  logic [VW-1:0]     load_codes,
  input  logic [ROW_W-1:0]  load_row,
  output logic              idle,
  output logic              push,
  output logic [ROW_W-1:0]  push_row,
  output logic [COL_W-1:0]  push_col,
  output logic [CODE_W-1:0] push_code
);
  logic [COLS-1:0]  mask;
  logic [VW-1:0]    codes;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] idx;

  // lowest marked column first
  always_comb begin
    idx = '0;
    for (int i = COLS - 1; i >= 0; i--)
      if (mask[i]) idx = COL_W'(i);
  end

  assign push      = |mask;
  assign idle      = ~push;
  assign push_row  = row;
  assign push_col  = idx;
  assign push_code = codes[int'(idx)*CODE_W +: CODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '0;
      codes <= '0;
      row   <= '0;
    end else if (load) begin
      mask  <= load_mask;
      codes <= load_codes;
      row   <= load_row;
    end else if (push) begin
      mask[idx] <= 1'b0;
    end
  end

  // R4: one pixel leaves per cycle, columns strictly rising within a row
  p_one_per_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !load) |=> ($countones(mask) + 1 == $past($countones(mask))));
  p_col_rising_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !load) |=> (!push || push_col > $past(push_col)));
endmodule

// File: rtl/pcs_fifo.sv
module pcs_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          full, do_wr, do_rd;

  assign full      = (count == (AW+1)'(DEPTH));
  assign not_empty = (count != '0);
  assign do_wr     = wr && !full;
  assign do_rd     = rd && not_empty;
  assign rdata     = mem[rptr];

  always_ff @(posedge clk)
    if (do_wr) mem[wptr] <= wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr && full) ovf <= 1'b1;
    end
  end

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(wr && full));
  p_full_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (full && !rd) |=> full);
  p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && !wr) |=> !not_empty);
endmodule

// File: rtl/pix_cluster_sparsifier.sv
module pix_cluster_sparsifier #(
  parameter int COLS       = 125,
  parameter int CODE_W     = 5,
  parameter int ROW_W      = 8,
  parameter int HALF       = 3,
  parameter int FIFO_DEPTH = 16,
  localparam int COL_W = $clog2(COLS),
  localparam int SUM_W = CODE_W + 2,
  localparam int VW    = COLS * CODE_W,
  localparam int NFLAG = 2 * HALF + 1,
  localparam int NDATA = HALF + 1,
  localparam int CW    = $clog2(NDATA + 1),
  localparam int ENT_W = ROW_W + COL_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SUM_W-1:0]  thresh,
  input  logic              row_valid,
  input  logic              row_last,
  input  logic [VW-1:0]     row_codes,
  input  logic              pop,
  output logic              out_valid,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic [CODE_W-1:0] out_code,
  output logic              overflow
);
  logic [COLS-1:0] flg [NFLAG];
  logic [COLS-1:0] nf  [NFLAG];
  logic [VW-1:0]   dat [NDATA];
  logic [ROW_W:0]  vrow;
  logic [CW-1:0]   fl_cnt;
  logic [COLS-1:0] colmask;
  logic            scan_idle, flush_step, step, emit, kern_en;
  logic            push;
  logic [ROW_W-1:0]  push_row;
  logic [COL_W-1:0]  push_col;
  logic [CODE_W-1:0] push_code;
  logic [ENT_W-1:0]  rdata;

  assign flush_step = (fl_cnt != '0) && !row_valid && scan_idle;
  assign step       = row_valid || flush_step;
  assign kern_en    = row_valid && (vrow != '0);
  assign emit       = step && (vrow >= (ROW_W+1)'(NDATA));

  pcs_hitmap #(.COLS(COLS), .CODE_W(CODE_W), .HALF(HALF)) i_hitmap (
    .en(kern_en), .upper(dat[NDATA-1]), .lower(row_codes),
    .thresh(thresh), .colmask(colmask));

  // every buffered flag row takes the new marks; the window is NFLAG rows tall
  for (genvar k = 0; k < NFLAG; k++) begin : g_nf
    if (k < NFLAG - 1) begin : g_mid
      assign nf[k] = flg[k+1] | colmask;
    end else begin : g_top
      assign nf[k] = colmask;
    end
  end

  pcs_rowscan #(.COLS(COLS), .CODE_W(CODE_W), .ROW_W(ROW_W)) i_scan (
    .clk(clk), .rst(rst), .load(emit), .load_mask(nf[0]), .load_codes(dat[0]),
    .load_row(ROW_W'(vrow - (ROW_W+1)'(NDATA))), .idle(scan_idle),
    .push(push), .push_row(push_row), .push_col(push_col), .push_code(push_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NFLAG; k++) flg[k] <= '0;
      for (int k = 0; k < NDATA; k++) dat[k] <= '0;
      vrow   <= '0;
      fl_cnt <= '0;
    end else if (step) begin
      for (int k = 0; k < NFLAG; k++) flg[k] <= nf[k];
      for (int k = 0; k < NDATA - 1; k++) dat[k] <= dat[k+1];
      dat[NDATA-1] <= row_valid ? row_codes : '0;
      vrow <= vrow + 1'b1;
      if (row_valid && row_last) begin
        fl_cnt <= CW'(NDATA);
      end else if (flush_step) begin
        fl_cnt <= fl_cnt - 1'b1;
        if (fl_cnt == CW'(1)) begin
          // frame closed: drop marks that point past its last row
          vrow <= '0;
          for (int k = 0; k < NFLAG; k++) flg[k] <= '0;
          for (int k = 0; k < NDATA; k++) dat[k] <= '0;
        end
      end
    end
  end

  pcs_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .wr(push), .wdata({push_row, push_col, push_code}),
    .rd(pop), .rdata(rdata), .not_empty(out_valid), .ovf(overflow));

  assign {out_row, out_col, out_code} = rdata;

  // R5: a row is handed over only to an idle scanner (input spacing rule)
  p_load_idle_r5: assert property (@(posedge clk) disable iff (rst) emit |-> scan_idle);
  // R9: closing a frame restarts row numbering
  p_frame_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (flush_step && fl_cnt == CW'(1)) |=> (vrow == '0));
endmodule

// File: tb/test_pix_cluster_sparsifier.sv
`timescale 1ns/1ps
module test_pix_cluster_sparsifier;
  localparam int COLS = 125;
  localparam int HALF = 3;
  localparam int DEPTH = 16;
  localparam int MAXR = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [6:0]   thresh;
  logic         row_valid, row_last, pop;
  logic [COLS*5-1:0] row_codes;
  logic         out_valid, overflow;
  logic [7:0]   out_row;
  logic [6:0]   out_col;
  logic [4:0]   out_code;

  int fr [MAXR][COLS];
  bit mk [MAXR][COLS];
  int got_r[$], got_c[$], got_v[$];
  int exp_r[$], exp_c[$], exp_v[$];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pix_cluster_sparsifier i_pix_cluster_sparsifier (
    .clk(clk), .rst(rst), .thresh(thresh), .row_valid(row_valid), .row_last(row_last),
    .row_codes(row_codes), .pop(pop), .out_valid(out_valid), .out_row(out_row),
    .out_col(out_col), .out_code(out_code), .overflow(overflow));

  always @(negedge clk)
    if (!rst && out_valid && pop) begin
      got_r.push_back(int'(out_row));
      got_c.push_back(int'(out_col));
      got_v.push_back(int'(out_code));
    end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(int maxbg);
    for (int r = 0; r < MAXR; r++)
      for (int c = 0; c < COLS; c++)
        fr[r][c] = (maxbg == 0) ? 0 : int'($urandom_range(0, maxbg));
  endtask

  task automatic blob(int r, int c, int v);
    fr[r][c] = v; fr[r][c+1] = v; fr[r+1][c] = v; fr[r+1][c+1] = v;
  endtask

  task automatic model(int nrows, int thr);
    exp_r.delete(); exp_c.delete(); exp_v.delete();
    for (int r = 0; r < MAXR; r++)
      for (int c = 0; c < COLS; c++) mk[r][c] = 1'b0;
    for (int r0 = 0; r0 < nrows - 1; r0++)
      for (int c0 = 0; c0 < COLS - 1; c0++)
        if (fr[r0][c0] + fr[r0][c0+1] + fr[r0+1][c0] + fr[r0+1][c0+1] > thr)
          for (int dr = -HALF; dr <= HALF; dr++)
            for (int dc = -HALF; dc <= HALF; dc++)
              if (r0+dr >= 0 && r0+dr < nrows && c0+dc >= 0 && c0+dc < COLS)
                mk[r0+dr][c0+dc] = 1'b1;
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < COLS; c++)
        if (mk[r][c]) begin
          exp_r.push_back(r); exp_c.push_back(c); exp_v.push_back(fr[r][c]);
        end
  endtask

  task automatic send_row(int r, bit last);
    @(posedge clk); #1;
    for (int c = 0; c < COLS; c++) row_codes[c*5 +: 5] = 5'(fr[r][c]);
    row_valid = 1'b1; row_last = last;
    @(posedge clk); #1;
    row_valid = 1'b0; row_last = 1'b0;
    repeat (COLS + 4) @(posedge clk);
  endtask

  task automatic send_frame(int nrows);
    for (int r = 0; r < nrows; r++) send_row(r, r == nrows - 1);
    repeat ((HALF + 2) * (COLS + 4) + DEPTH + 10) @(posedge clk);
  endtask

  // limit < 0 compares every expected entry
  task automatic compare(string tag, int limit);
    int n;
    n = (limit < 0) ? exp_r.size() : limit;
    check(got_r.size() == n, {tag, " R3 count"}, got_r.size(), n);
    for (int i = 0; i < n && i < got_r.size(); i++) begin
      check(got_r[i] == exp_r[i], {tag, " R4 row"}, got_r[i], exp_r[i]);
      check(got_c[i] == exp_c[i], {tag, " R4 col"}, got_c[i], exp_c[i]);
      check(got_v[i] == exp_v[i], {tag, " R4 code"}, got_v[i], exp_v[i]);
    end
    got_r.delete(); got_c.delete(); got_v.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20061));
    rst = 1'b1; row_valid = 1'b0; row_last = 1'b0; pop = 1'b1;
    thresh = 7'd20; row_codes = '0;
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 empty after reset", out_valid, 0);
    check(overflow == 1'b0, "R8 overflow after reset", overflow, 0);

    // R1: sum equal to threshold is no hit, one above is
    fill(0); blob(4, 60, 5); model(10, 20);
    send_frame(10);
    check(got_r.size() == 0, "R1 equal sum", got_r.size(), 0);
    compare("R1 equal", -1);
    fill(0); blob(4, 60, 5); fr[5][61] = 6; model(10, 20);
    send_frame(10);
    check(got_r.size() == 49, "R1 above sum", got_r.size(), 49);
    compare("R1 above", -1);

    // R2: clipping at all four edges
    fill(0); blob(0, 0, 6); blob(8, 123, 6); model(10, 20);
    send_frame(10);
    check(got_r.size() == 41, "R2 clipped total", got_r.size(), 41);
    compare("R2 corners", -1);
    fill(0); blob(0, 123, 6); blob(8, 0, 6); model(10, 20);
    send_frame(10);
    compare("R2 other corners", -1);

    // R3: overlapping windows merged
    fill(0); blob(4, 50, 7); blob(6, 53, 7); blob(5, 51, 6); model(12, 20);
    send_frame(12);
    compare("R3 overlap", -1);

    // R5: row 0 released only when row 4 arrives
    fill(0); blob(0, 20, 8); model(12, 20);
    for (int r = 0; r < 4; r++) send_row(r, 1'b0);
    @(negedge clk);
    check(got_r.size() == 0, "R5 held before row 4", got_r.size(), 0);
    send_row(4, 1'b0);
    @(negedge clk);
    check(got_r.size() == 7, "R5 row 0 after row 4", got_r.size(), 7);
    for (int r = 5; r < 12; r++) send_row(r, r == 11);
    repeat ((HALF + 2) * (COLS + 4) + DEPTH + 10) @(posedge clk);
    compare("R5 frame", -1);

    // R9: hit in the last rows does not spill into the next frame
    fill(0); blob(4, 70, 9); model(6, 20);
    send_frame(6);
    compare("R9 ending frame", -1);
    fill(0); model(6, 20);
    send_frame(6);
    check(got_r.size() == 0, "R9 quiet next frame", got_r.size(), 0);
    compare("R9 next frame", -1);

    // random frames
    for (int t = 0; t < 8; t++) begin
      int nr, thr, nb;
      nr  = int'($urandom_range(5, 14));
      thr = int'($urandom_range(20, 27));
      fill(5);
      nb = int'($urandom_range(1, 3));
      for (int b = 0; b < nb; b++)
        blob(int'($urandom_range(0, nr - 2)), int'($urandom_range(0, COLS - 2)),
             int'($urandom_range(6, 12)));
      @(posedge clk); #1; thresh = 7'(thr);
      model(nr, thr);
      send_frame(nr);
      compare("random R2", -1);
    end

    // R6: pop on empty FIFO does nothing
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 pop on empty", out_valid, 0);
    check(got_r.size() == 0, "R6 no entry from empty pop", got_r.size(), 0);

    // R7 boundary: exactly DEPTH entries held without pop
    @(posedge clk); #1; pop = 1'b0; thresh = 7'd20;
    fill(0); blob(0, 0, 6); model(8, 20);
    send_frame(8);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 entries held", out_valid, 1);
    check(overflow == 1'b0, "R7 exactly full", overflow, 0);
    @(posedge clk); #1; pop = 1'b1;
    repeat (DEPTH + 5) @(posedge clk);
    compare("R7 full boundary", -1);

    // R7: beyond depth, extra entries dropped and flag sticks
    @(posedge clk); #1; pop = 1'b0;
    fill(0); blob(5, 40, 9); model(12, 20);
    send_frame(12);
    @(negedge clk);
    check(overflow == 1'b1, "R7 overflow set", overflow, 1);
    @(posedge clk); #1; pop = 1'b1;
    repeat (DEPTH + 5) @(posedge clk);
    compare("R7 kept entries", DEPTH);
    @(negedge clk);
    check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);

    // R8: reset clears the flag
    @(posedge clk); #1; rst = 1'b1;
    repeat (2) @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(overflow == 1'b0, "R8 overflow cleared", overflow, 0);
    check(out_valid == 1'b0, "R8 FIFO cleared", out_valid, 0);

    finish_run();
  end
endmodule